// File: doc/BRIEF.md
# Multi-Range PWM Timer with Auto-Reload

This block is an 8-bit up-counting timer. A prescaler divides an incoming clock-enable tick by a power of two, and each divided tick advances the counter. With the PWM mode off, the counter runs through the full 8-bit span. When it passes 0xFF it restarts from zero, or from a programmable reload value if auto-reload is on. With the PWM mode on, a two-bit range code shortens the period to 256, 64, 32 or 16 counts. The reload register then acts as the compare value: the output is high while the count is below it and low from the compare value up to the end of the period.

Every period boundary raises a one-cycle interrupt pulse, so the interrupt rate follows the selected range. A compare value written during a PWM period takes effect at the next boundary, so the running period keeps its own duty. Software loads the counter and the reload register through write strobes. A counter write overrides the step in the same cycle.

Top module: `rangepwm_timer`

## Requirements
- R1: While reset is held and on the first cycles after it, the count is 0 and the PWM output and the interrupt pulse are low.
- R2: The rate code r (0 to 7) makes the counter advance once every 2^(7-r) ticks counted while the run input is high. Code 0 is divide-by-128 and code 7 advances on every tick. The tick divider is cleared whenever the run input is low.
- R3: With PWM off and auto-reload off, the counter steps from 0xFF to 0x00.
- R4: With PWM off and auto-reload on, the counter steps from 0xFF to the reload register value.
- R5: With PWM on, range code 0, 1, 2 or 3 makes 255, 63, 31 or 15 the last count, after which the counter goes to 0. The auto-reload input has no effect in this mode.
- R6: The interrupt output is high for exactly one cycle, the cycle in which the counter shows the value it took at a period boundary.
- R7: With PWM on, the output is high while the count is below the active compare value and low otherwise. With PWM off, the output is low.
- R8: With PWM on, the active compare value takes the reload register only at a period boundary. With PWM off, the compare value follows the reload register.
- R9: A compare value of 0 keeps the PWM output low. A compare value above the last count of the range keeps it high.
- R10: A counter write sets the count to the written value in the next cycle, overrides any step in that cycle, and raises no interrupt.
- R11: With the run input low and no write, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Clock-enable tick from the instruction clock |
| run_i | input | 1 | Counter enable |
| rate_i | input | 3 | Prescaler rate code, 0 slowest |
| pwm_en_i | input | 1 | PWM mode enable |
| range_i | input | 2 | PWM period code: 0=256, 1=64, 2=32, 3=16 counts |
| reload_en_i | input | 1 | Auto-reload enable (PWM off only) |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Counter write data |
| rld_wr_i | input | 1 | Reload/compare register write strobe |
| rld_wdata_i | input | 8 | Reload/compare write data |
| cnt_o | output | 8 | Current count |
| pwm_o | output | 1 | PWM / compare output |
| irq_o | output | 1 | Period-boundary interrupt pulse |

## Verification
On every cycle, the assertions check the following: the count holds without a step, a write lands with no interrupt, the count stays within the selected range, the counter is zero whenever a PWM boundary fires, a high PWM output means the count is below the active compare, and the compare is frozen mid-period. The bench's scenarios are needed for the rest. They measure the exact prescaler division, the reload value reached after a wrap, the deferred compare update seen on the output waveform, and the constant-low and constant-high duty extremes, all against a cycle model run alongside random mode changes.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic [1:0] {
    RNG_FULL = 2'd0,
    RNG_64   = 2'd1,
    RNG_32   = 2'd2,
    RNG_16   = 2'd3
  } rng_e;

  // right shift that turns an all-ones count into the last count of a period
  function automatic logic [2:0] range_shift(input logic pwm_en, input rng_e rng);
    if (!pwm_en || rng == RNG_FULL) return 3'd0;
    return 3'(rng) + 3'd1;
  endfunction
endpackage

// File: rtl/rpt_prescale.sv
module rpt_prescale #(
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              step_o
);
  localparam int PRE_W = (1 << RATE_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb mask = {PRE_W{1'b1}} >> rate_i;

  always_comb begin
    pre_d = pre_q;
    if (!run_i)      pre_d = '0;
    else if (tick_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  assign step_o = tick_i & run_i & ((pre_q & mask) == mask);

  // R2
  step_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (tick_i && run_i));
endmodule

// File: rtl/rpt_count.sv
module rpt_count
  import rpt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             pwm_en_i,
  input  rng_e             range_i,
  input  logic             reload_en_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             rld_wr_i,
  input  logic [CNT_W-1:0] rld_wdata_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic [CNT_W-1:0] rld_q_o,
  output logic             wrap_evt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d, top_val;
  logic             wrap, irq_q;

  always_comb begin
    top_val    = {CNT_W{1'b1}} >> range_shift(pwm_en_i, range_i);
    wrap       = (cnt_q >= top_val);
    wrap_evt_o = step_i & wrap & ~cnt_wr_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr_i) begin
      cnt_d = cnt_wdata_i;
    end else if (step_i) begin
      if (!wrap)                       cnt_d = cnt_q + 1'b1;
      else if (!pwm_en_i && reload_en_i) cnt_d = rld_q;
      else                             cnt_d = '0;
    end
    rld_d = rld_wr_i ? rld_wdata_i : rld_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      irq_q <= wrap_evt_o;
    end
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;
  assign rld_q_o = rld_q;
  assign irq_o   = irq_q;

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !cnt_wr_i) |=> $stable(cnt_q));
  // R10
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_q == $past(cnt_wdata_i)) && !irq_q);
  // R5
  in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i && !cnt_wr_i && cnt_q <= top_val) |=> (cnt_q <= $past(top_val)));
  // R6
  irq_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && $past(pwm_en_i)) |-> (cnt_q == '0));
endmodule

// File: rtl/rpt_wave.sv
module rpt_wave #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_en_i,
  input  logic             wrap_evt_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic [CNT_W-1:0] cnt_q_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             pwm_q, pwm_d;

  always_comb begin
    cmp_d = (wrap_evt_i || !pwm_en_i) ? rld_i : cmp_q;
    pwm_d = pwm_en_i & (cnt_d_i < cmp_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

  // R7
  pwm_below_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_q |-> (cnt_q_i < cmp_q));
  // R8
  cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i && !wrap_evt_i) |=> $stable(cmp_q));
endmodule

// File: rtl/rangepwm_timer.sv
module rangepwm_timer
  import rpt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              pwm_en_i,
  input  logic [1:0]        range_i,
  input  logic              reload_en_i,
  input  logic              cnt_wr_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              rld_wr_i,
  input  logic [CNT_W-1:0]  rld_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pwm_o,
  output logic              irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s, step, wrap_evt;
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  rpt_prescale #(.RATE_W(RATE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_n_s), .tick_i(tick_i), .run_i(run_i),
    .rate_i(rate_i), .step_o(step)
  );

  rpt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n_s), .step_i(step), .pwm_en_i(pwm_en_i),
    .range_i(rng_e'(range_i)), .reload_en_i(reload_en_i),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .rld_wr_i(rld_wr_i), .rld_wdata_i(rld_wdata_i),
    .cnt_q_o(cnt_q), .cnt_d_o(cnt_d), .rld_q_o(rld_q),
    .wrap_evt_o(wrap_evt), .irq_o(irq_o)
  );

  rpt_wave #(.CNT_W(CNT_W)) u_wave (
    .clk_i(clk_i), .rst_ni(rst_n_s), .pwm_en_i(pwm_en_i),
    .wrap_evt_i(wrap_evt), .rld_i(rld_q), .cnt_q_i(cnt_q), .cnt_d_i(cnt_d),
    .pwm_o(pwm_o)
  );

  assign cnt_o = cnt_q;

  // R7
  pwm_off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !pwm_en_i |=> !pwm_o);
endmodule

// File: tb/rangepwm_timer_bench.sv
module rangepwm_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, run, pwm_en, reload_en, cnt_wr, rld_wr;
  logic [2:0] rate;
  logic [1:0] range;
  logic [7:0] cnt_wdata, rld_wdata;
  logic [7:0] cnt;
  logic       pwm, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit [6:0] m_pre;
  bit [7:0] m_cnt, m_rld, m_cmp;
  bit       m_pwm, m_irq;

  always #10 clk = ~clk;

  rangepwm_timer u_rangepwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run), .rate_i(rate),
    .pwm_en_i(pwm_en), .range_i(range), .reload_en_i(reload_en),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata), .rld_wr_i(rld_wr),
    .rld_wdata_i(rld_wdata), .cnt_o(cnt), .pwm_o(pwm), .irq_o(irq)
  );

  function automatic bit [7:0] last_count(bit pe, bit [1:0] rg);
    if (!pe) return 8'hFF;
    case (rg)
      2'd0: return 8'd255;
      2'd1: return 8'd63;
      2'd2: return 8'd31;
      default: return 8'd15;
    endcase
  endfunction

  function automatic bit [6:0] div_mask(bit [2:0] r);
    return 7'h7F >> r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit step, wrap, wevt;
    bit [7:0] n_cnt, n_cmp;
    step = tick && run && ((m_pre & div_mask(rate)) == div_mask(rate));
    wrap = m_cnt >= last_count(pwm_en, range);
    wevt = step && wrap && !cnt_wr;
    if (cnt_wr)      n_cnt = cnt_wdata;
    else if (!step)  n_cnt = m_cnt;
    else if (!wrap)  n_cnt = m_cnt + 8'd1;
    else if (!pwm_en && reload_en) n_cnt = m_rld;
    else             n_cnt = 8'd0;
    n_cmp = (wevt || !pwm_en) ? m_rld : m_cmp;
    m_pwm = pwm_en && (n_cnt < n_cmp);
    m_irq = wevt;
    m_cmp = n_cmp;
    m_cnt = n_cnt;
    if (rld_wr) m_rld = rld_wdata;
    if (!run) m_pre = '0;
    else if (tick) m_pre = m_pre + 7'd1;
  endtask

  task automatic compare_all();
    check(cnt == m_cnt, pwm_en ? "R5 count" : "R3/R4 count", cnt, m_cnt);
    check(irq == m_irq, "R6 irq", irq, m_irq);
    check(pwm == m_pwm, "R7 pwm", pwm, m_pwm);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    cnt_wr = 1'b0;
    rld_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int n;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; tick = 0; run = 0; rate = 3'd7; pwm_en = 0; range = 0;
    reload_en = 0; cnt_wr = 0; rld_wr = 0; cnt_wdata = 0; rld_wdata = 0;
    m_pre = '0; m_cnt = '0; m_rld = '0; m_cmp = '0; m_pwm = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cnt == 8'd0, "R1 count", cnt, 0);
    check(pwm == 1'b0, "R1 pwm", pwm, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cnt == 8'd0 && !pwm && !irq, "R1 after release", cnt, 0);

    // random mix: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 6000; i++) begin
      if (i % 150 == 0) begin
        pwm_en    = $urandom_range(0, 1);
        range     = 2'($urandom_range(0, 3));
        reload_en = $urandom_range(0, 1);
        rate      = 3'($urandom_range(5, 7));
      end
      tick      = ($urandom_range(0, 3) != 0);
      run       = ($urandom_range(0, 15) != 0);
      cnt_wr    = ($urandom_range(0, 63) == 0);
      cnt_wdata = 8'($urandom_range(0, 255));
      rld_wr    = ($urandom_range(0, 31) == 0);
      rld_wdata = 8'($urandom_range(0, 70));
      cyc();
    end
    quiet();

    // R11: run low, count holds
    run = 0; tick = 1;
    cyc();
    n = cnt;
    repeat (20) cyc();
    check(cnt == 8'(n), "R11 hold", cnt, n);

    // R2: divide-by-128 at rate 0
    pwm_en = 0; reload_en = 0; rate = 3'd0;
    cnt_wr = 1; cnt_wdata = 8'd0; cyc(); quiet();
    run = 1; tick = 1;
    n = 0;
    while (cnt == 8'd0 && n < 300) begin cyc(); n++; end
    check(n == 128, "R2 divide", n, 128);

    // R4: reload after 0xFF
    rate = 3'd7; reload_en = 1;
    rld_wr = 1; rld_wdata = 8'hF0; cnt_wr = 1; cnt_wdata = 8'hFE; cyc(); quiet();
    cyc();
    check(cnt == 8'hFF, "R4 before wrap", cnt, 8'hFF);
    cyc();
    check(cnt == 8'hF0 && irq, "R4 reload", cnt, 8'hF0);
    // R3: no reload
    reload_en = 0;
    cnt_wr = 1; cnt_wdata = 8'hFF; cyc(); quiet();
    cyc();
    check(cnt == 8'h00 && irq, "R3 wrap", cnt, 0);

    // R10: write at a wrap point overrides, no irq
    pwm_en = 1; range = 2'd3;
    cnt_wr = 1; cnt_wdata = 8'd15; cyc();
    cyc(); quiet();
    check(cnt == 8'd15 && !irq, "R10 write wins", cnt, 15);
    cyc();
    check(cnt == 8'd0 && irq, "R5 range16 wrap", cnt, 0);

    // R9 low: compare 0
    pwm_en = 0; rld_wr = 1; rld_wdata = 8'd0; cyc(); quiet(); cyc();
    pwm_en = 1; n = 0;
    for (int k = 0; k < 40; k++) begin cyc(); if (pwm) n++; end
    check(n == 0, "R9 const low", n, 0);
    // R9 high: compare above range
    pwm_en = 0; rld_wr = 1; rld_wdata = 8'd20; cyc(); quiet(); cyc();
    pwm_en = 1; n = 0;
    for (int k = 0; k < 40; k++) begin cyc(); if (!pwm) n++; end
    check(n == 0, "R9 const high", n, 0);

    // R8: compare change mid-period is deferred
    pwm_en = 0; rld_wr = 1; rld_wdata = 8'd8; cnt_wr = 1; cnt_wdata = 8'd0;
    cyc(); quiet(); cyc();
    pwm_en = 1;
    cyc(); cyc(); cyc();
    rld_wr = 1; rld_wdata = 8'd12; cyc(); quiet();
    n = 0;
    while (cnt != 8'd8 && n < 40) begin cyc(); n++; end
    check(pwm == 1'b0, "R8 old compare kept", pwm, 0);
    n = 0;
    while (!irq && n < 40) begin cyc(); n++; end
    n = 0;
    while (cnt != 8'd10 && n < 40) begin cyc(); n++; end
    check(pwm == 1'b1, "R8 new compare at boundary", pwm, 1);

    // R7: PWM off forces low
    pwm_en = 0; cyc();
    check(pwm == 1'b0, "R7 off low", pwm, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule